// File: doc/BRIEF.md
# Snooping MESI Line Controller with Pending-Upgrade States

This block holds the coherence state of a small direct-mapped, write-back cache that sits on an atomic snooping bus. It keeps one MESI state and one tag for each line. It takes one processor read or write at a time. A request that hits a line in a state that permits the access completes without the bus. Every other request leaves a transient record that waits for the bus. Once the external arbiter grants the bus, the controller drives exactly one command: a read, a read-exclusive, or an ownership upgrade that carries no data.

While a request waits, the controller keeps answering snooped transactions from other caches. It drives a shared indication for any valid copy it holds and a dirty indication when it holds the only modified copy. A dirty indication also means the data will be supplied. The controller compares each snooped invalidating transaction with its own waiting upgrade. When another cache wins the bus first for the same line, the local copy is dropped and the waiting upgrade is turned into a read-exclusive. Tag and state are kept in two copies, one read by the processor side and one read by the snoop side. Every change is written to both copies in the same cycle.

The processor interface is valid/ready. A request is taken in a cycle where `cpu_valid` and `cpu_ready` are both high. The requester keeps `cpu_write` and `cpu_addr` unchanged until that cycle. `cpu_ready` is low while a request waits for the bus and in any cycle that carries a snoop. The outcome is a single-cycle `cpu_done` pulse. Bus and snoop pins are plain control signals.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop gets a response, `bus_req` is low and `cpu_ready` is high.
- R2: A read miss raises `bus_req` from the cycle after acceptance. In the grant cycle `bus_cmd_valid` is high with `bus_cmd` = 2'b01 (read), and `cpu_done` pulses in the next cycle. The line is filled Exclusive if `bus_shared_in` was low in the grant cycle and Shared otherwise.
- R3: A write that hits a line in Exclusive makes it Modified without any bus activity, and `cpu_done` pulses in the cycle after acceptance. Read hits and write hits in Modified also complete in that cycle.
- R4: A write that hits a Shared line does not make it Modified straight away. `bus_req` rises, and the grant cycle carries `bus_cmd` = 2'b11 (upgrade). The line is Modified after that cycle.
- R5: A snooped read-exclusive (2'b10) or upgrade (2'b11) to the line of a waiting upgrade invalidates the local copy. The command later driven in the grant cycle is then 2'b10, and the line is Modified after it.
- R6: A snooped read (2'b01) on a line held Modified asserts `snp_shared` and `snp_dirty`. On a line held Exclusive or Shared it asserts `snp_shared` only. In every case the line becomes Shared.
- R7: A snooped read-exclusive or upgrade on a valid line asserts `snp_shared`, asserts `snp_dirty` if the line was Modified, and leaves the line Invalid.
- R8: `cpu_ready` is low whenever a request is waiting for the bus and in every cycle with `snp_valid` high. At most one request is outstanding.
- R9: While a request waits for the bus, snoops to other lines are answered and applied as in R6 and R7.
- R10: A write miss drives `bus_cmd` = 2'b10 in the grant cycle, and the line is Modified afterwards. `bus_cmd_addr` holds the waiting line's address, with the offset bits zero, for as long as `bus_req` is high.
- R11: When a fill replaces a Modified line that has a different tag, `bus_wb_valid` is high in the grant cycle and `bus_wb_addr` gives the victim's line address. An upgrade never evicts.
- R12: With `snp_valid` low, or with a snoop address whose tag differs from the stored one, `snp_shared` and `snp_dirty` stay low. The offset bits of any address are ignored.
- R13: A change made through the processor side is seen by the next snoop, and a change made by a snoop is seen by the next processor lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller can take a request this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request byte address |
| cpu_done | output | 1 | One-cycle pulse: the request has completed |
| bus_req | output | 1 | Bus wanted for the waiting request |
| bus_gnt | input | 1 | Bus granted to this controller this cycle |
| bus_cmd_valid | output | 1 | Command on the bus this cycle |
| bus_cmd | output | 2 | 01 read, 10 read-exclusive, 11 upgrade |
| bus_cmd_addr | output | ADDR_W | Line address of the waiting request |
| bus_shared_in | input | 1 | Wired-OR shared from other caches, in the grant cycle |
| bus_wb_valid | output | 1 | Victim must be written back (grant cycle) |
| bus_wb_addr | output | ADDR_W | Victim line address |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_dirty | output | 1 | This cache holds the copy Modified and supplies data |

## Verification
The checks assume the atomic bus never shows another cache's transaction in a cycle where this controller is granted, so `snp_valid` and `bus_gnt` are never high together. The arbiter raises `bus_gnt` only while `bus_req` is high. The stimulus meets both: a grant is given only while the reference model has a waiting request, and that cycle carries no snoop. The requester holds the request fields until acceptance. In the random phase, snooped commands are any of the three codes on a few tags, so that conflicts with the waiting upgrade and victim evictions come up often.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_UPGR = 2'd3} bus_cmd_t;
  // waiting-request kinds: fill for read, upgrade S->M, fill for write (I->M)
  typedef enum logic [1:0] {PK_NONE = 2'd0, PK_FILL_RD = 2'd1, PK_UPG = 2'd2, PK_FILL_WR = 2'd3} pend_t;
endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_ctrl_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st,
  input  logic [IDX_W-1:0] pa_idx,
  output logic [TAG_W-1:0] pa_tag,
  output line_st_t         pa_st,
  input  logic [IDX_W-1:0] pb_idx,
  output logic [TAG_W-1:0] pb_tag,
  output line_st_t         pb_st,
  input  logic [IDX_W-1:0] s_idx,
  output logic [TAG_W-1:0] s_tag,
  output line_st_t         s_st
);
  localparam int LINES  = 1 << IDX_W;
  localparam int COPIES = 2;  // copy 0: processor side, copy 1: snoop side

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [TAG_W-1:0] tag_q [LINES];
    line_st_t         st_q  [LINES];

    // both copies take the same single write, so they never diverge (R13)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LINES; i++) begin
          tag_q[i] <= '0;
          st_q[i]  <= LN_I;
        end
      end else if (wr_en) begin
        tag_q[wr_idx] <= wr_tag;
        st_q[wr_idx]  <= wr_st;
      end
    end
  end

  assign pa_tag = g_copy[0].tag_q[pa_idx];
  assign pa_st  = g_copy[0].st_q[pa_idx];
  assign pb_tag = g_copy[0].tag_q[pb_idx];
  assign pb_st  = g_copy[0].st_q[pb_idx];
  assign s_tag  = g_copy[1].tag_q[s_idx];
  assign s_st   = g_copy[1].st_q[s_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_ctrl_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             resp_shared,
  output logic             resp_dirty,
  output logic             upd_en,
  output line_st_t         upd_st
);
  logic hit;

  always_comb begin
    hit         = snp_valid && (snp_cmd != BC_NONE) && (line_st != LN_I) && (line_tag == snp_tag);
    resp_shared = hit;                              // R6 R7
    resp_dirty  = hit && (line_st == LN_M);         // owner supplies data
    upd_en      = hit;
    upd_st      = (snp_cmd == BC_RD) ? LN_S : LN_I; // R6 downgrade, R7 invalidate
  end
endmodule

// File: rtl/mesi_req_tracker.sv
module mesi_req_tracker
  import mesi_ctrl_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  pend_t             new_kind,
  input  logic [LINE_W-1:0] new_line,
  input  logic              grant,
  input  logic              snp_valid,
  input  bus_cmd_t          snp_cmd,
  input  logic [LINE_W-1:0] snp_line,
  output pend_t             kind,
  output logic [LINE_W-1:0] line,
  output logic              done
);
  logic conflict;
  logic hit_done;

  // another cache took ownership of the line we wanted to upgrade (R5)
  assign conflict = snp_valid && ((snp_cmd == BC_RDX) || (snp_cmd == BC_UPGR)) &&
                    (kind == PK_UPG) && (snp_line == line);
  assign hit_done = accept && (new_kind == PK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= PK_NONE;
      line <= '0;
      done <= 1'b0;
    end else begin
      done <= (grant && (kind != PK_NONE)) || hit_done;
      if (grant && (kind != PK_NONE)) begin
        kind <= PK_NONE;
      end else if (conflict) begin
        kind <= PK_FILL_WR;
      end else if (accept && (new_kind != PK_NONE)) begin
        kind <= new_kind;
        line <= new_line;
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  input  logic              bus_shared_in,
  output logic              bus_wb_valid,
  output logic [ADDR_W-1:0] bus_wb_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_dirty
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  logic [LINE_W-1:0] cpu_line, snp_line_a, pend_line;
  logic [IDX_W-1:0]  cpu_idx, snp_idx, pend_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, pend_tag;
  logic [TAG_W-1:0]  pa_tag, pb_tag, s_tag;
  line_st_t          pa_st, pb_st, s_st;
  bus_cmd_t          snp_cmd_e, cmd_e;
  pend_t             pend_kind, new_kind;
  logic              accept, cpu_hit, cpu_silent, grant;
  logic              s_upd_en;
  line_st_t          s_upd_st, fill_st;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  line_st_t          wr_st;
  logic              unused_offset_bits;

  assign unused_offset_bits = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};  // R12

  assign cpu_line   = cpu_addr[ADDR_W-1:OFF_W];
  assign cpu_idx    = cpu_line[IDX_W-1:0];
  assign cpu_tag    = cpu_line[LINE_W-1:IDX_W];
  assign snp_line_a = snp_addr[ADDR_W-1:OFF_W];
  assign snp_idx    = snp_line_a[IDX_W-1:0];
  assign snp_tag    = snp_line_a[LINE_W-1:IDX_W];
  assign pend_idx   = pend_line[IDX_W-1:0];
  assign pend_tag   = pend_line[LINE_W-1:IDX_W];
  assign snp_cmd_e  = bus_cmd_t'(snp_cmd);

  // processor side: one outstanding request, stalled during snoops (R8)
  assign cpu_ready = (pend_kind == PK_NONE) && !snp_valid;
  assign accept    = cpu_valid && cpu_ready;
  assign cpu_hit   = (pa_st != LN_I) && (pa_tag == cpu_tag);

  always_comb begin
    if (!cpu_write)
      new_kind = cpu_hit ? PK_NONE : PK_FILL_RD;                       // R2 R3
    else if (cpu_hit && ((pa_st == LN_M) || (pa_st == LN_E)))
      new_kind = PK_NONE;                                              // R3
    else if (cpu_hit)
      new_kind = PK_UPG;                                               // R4
    else
      new_kind = PK_FILL_WR;                                           // R10
  end

  assign cpu_silent = accept && cpu_write && cpu_hit && (pa_st == LN_E);

  // bus side
  assign bus_req       = (pend_kind != PK_NONE);
  assign grant         = bus_gnt && bus_req;
  assign bus_cmd_valid = grant;
  assign bus_cmd_addr  = {pend_line, {OFF_W{1'b0}}};

  always_comb begin
    unique case (pend_kind)
      PK_FILL_RD: cmd_e = BC_RD;
      PK_UPG:     cmd_e = BC_UPGR;
      PK_FILL_WR: cmd_e = BC_RDX;
      default:    cmd_e = BC_NONE;
    endcase
    if (!grant) cmd_e = BC_NONE;
  end
  assign bus_cmd = cmd_e;

  // a fill that lands on a dirty line of another tag pushes it out (R11)
  assign bus_wb_valid = grant && (pb_st == LN_M) && (pb_tag != pend_tag);
  assign bus_wb_addr  = {pb_tag, pend_idx, {OFF_W{1'b0}}};
  assign fill_st      = (pend_kind == PK_FILL_RD) ? (bus_shared_in ? LN_S : LN_E) : LN_M;

  // single update path into both tag copies: snoop, then grant, then silent upgrade
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = cpu_idx;
    wr_tag = cpu_tag;
    wr_st  = LN_M;
    if (s_upd_en) begin
      wr_en  = 1'b1;
      wr_idx = snp_idx;
      wr_tag = s_tag;
      wr_st  = s_upd_st;
    end else if (grant) begin
      wr_en  = 1'b1;
      wr_idx = pend_idx;
      wr_tag = pend_tag;
      wr_st  = fill_st;
    end else if (cpu_silent) begin
      wr_en  = 1'b1;
    end
  end

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .wr_st  (wr_st),
    .pa_idx (cpu_idx),
    .pa_tag (pa_tag),
    .pa_st  (pa_st),
    .pb_idx (pend_idx),
    .pb_tag (pb_tag),
    .pb_st  (pb_st),
    .s_idx  (snp_idx),
    .s_tag  (s_tag),
    .s_st   (s_st)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd_e),
    .snp_tag     (snp_tag),
    .line_tag    (s_tag),
    .line_st     (s_st),
    .resp_shared (snp_shared),
    .resp_dirty  (snp_dirty),
    .upd_en      (s_upd_en),
    .upd_st      (s_upd_st)
  );

  mesi_req_tracker #(.LINE_W(LINE_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .new_kind  (new_kind),
    .new_line  (cpu_line),
    .grant     (grant),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd_e),
    .snp_line  (snp_line_a),
    .kind      (pend_kind),
    .line      (pend_line),
    .done      (cpu_done)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cmd_valid,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_cmd_addr,
  input logic              bus_wb_valid,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared,
  input logic              snp_dirty
);
  logic same_line_inval;
  assign same_line_inval = snp_valid && (snp_cmd[1] == 1'b1) &&
                           ((snp_addr >> OFF_W) == (bus_cmd_addr >> OFF_W));

  AST_IN_NO_SNOOP_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && bus_gnt)); // R9
  AST_CMD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (bus_gnt && bus_req)); // R4
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || snp_valid) |-> !cpu_ready); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd_addr))); // R10
  AST_NO_STALE_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && same_line_inval) |=> !(bus_cmd_valid && bus_cmd == 2'b11)); // R5
  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> cpu_done); // R2
  AST_DIRTY_IMPLIES_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> snp_shared); // R7
  AST_QUIET_WITHOUT_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !(snp_shared || snp_dirty)); // R12
  AST_WB_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb_valid |-> (bus_cmd_valid && bus_cmd != 2'b11)); // R11
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ready     (cpu_ready),
  .cpu_done      (cpu_done),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_cmd_valid (bus_cmd_valid),
  .bus_cmd       (bus_cmd),
  .bus_cmd_addr  (bus_cmd_addr),
  .bus_wb_valid  (bus_wb_valid),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_addr      (snp_addr),
  .snp_shared    (snp_shared),
  .snp_dirty     (snp_dirty)
);

// File: tb/tb_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_snoop_ctrl;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 2;
  localparam int OFF_W  = 4;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid, cpu_ready, cpu_write, cpu_done;
  logic [ADDR_W-1:0] cpu_addr, bus_cmd_addr, bus_wb_addr, snp_addr;
  logic bus_req, bus_gnt, bus_cmd_valid, bus_shared_in, bus_wb_valid;
  logic [1:0] bus_cmd, snp_cmd;
  logic snp_valid, snp_shared, snp_dirty;

  always #4 clk = ~clk;  // 125 MHz

  mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_cmd_addr(bus_cmd_addr), .bus_shared_in(bus_shared_in),
    .bus_wb_valid(bus_wb_valid), .bus_wb_addr(bus_wb_addr),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_dirty(snp_dirty)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int mk(input int tag, input int idx);
    return ((tag << IDX_W) | idx) << OFF_W;
  endfunction

  // ---------------- reference model (states 0 I, 1 S, 2 E, 3 M) ----------------
  int m_st [LINES];
  int m_tag[LINES];
  int m_pk = 0;      // 0 none, 1 read fill, 2 upgrade, 3 write fill
  int m_pline = 0;
  bit m_done = 0;
  bit last_acc = 0;

  always @(negedge clk) begin
    int sidx, stag, pidx, ptag, cidx, ctag, e_cmd, e_wbaddr;
    bit hit, chit, e_ready, e_req, e_cmdv, e_sh, e_dt, e_wb, acc, nd;
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
      m_pk = 0; m_pline = 0; m_done = 0;
    end
    sidx = (int'(snp_addr) >> OFF_W) & (LINES - 1);
    stag = int'(snp_addr) >> (OFF_W + IDX_W);
    hit  = snp_valid && snp_cmd != 0 && m_st[sidx] != 0 && m_tag[sidx] == stag;
    e_sh = hit;
    e_dt = hit && m_st[sidx] == 3;
    pidx = m_pline & (LINES - 1);
    ptag = m_pline >> IDX_W;
    e_req  = m_pk != 0;
    e_cmdv = e_req && bus_gnt;
    e_cmd  = !e_cmdv ? 0 : (m_pk == 1 ? 1 : (m_pk == 2 ? 3 : 2));
    e_wb   = e_cmdv && m_st[pidx] == 3 && m_tag[pidx] != ptag;
    e_wbaddr = mk(m_tag[pidx], pidx);
    e_ready = m_pk == 0 && !snp_valid;
    acc = e_ready && cpu_valid;

    check(cpu_ready === e_ready, "R8", "cpu_ready", cpu_ready, e_ready);
    check(cpu_done === m_done, "R3", "cpu_done", cpu_done, m_done);
    check(bus_req === e_req, "R4", "bus_req", bus_req, e_req);
    check(bus_cmd_valid === e_cmdv, "R2", "bus_cmd_valid", bus_cmd_valid, e_cmdv);
    check(int'(bus_cmd) == e_cmd, "R5", "bus_cmd", bus_cmd, e_cmd);
    if (e_req) check(int'(bus_cmd_addr) == (m_pline << OFF_W), "R10", "bus_cmd_addr",
                     bus_cmd_addr, m_pline << OFF_W);
    check(snp_shared === e_sh, "R6", "snp_shared", snp_shared, e_sh);
    check(snp_dirty === e_dt, "R7", "snp_dirty", snp_dirty, e_dt);
    check(bus_wb_valid === e_wb, "R11", "bus_wb_valid", bus_wb_valid, e_wb);
    if (e_wb) check(int'(bus_wb_addr) == e_wbaddr, "R11", "bus_wb_addr", bus_wb_addr, e_wbaddr);

    if (rst_n) begin
      nd = 0;
      if (hit) m_st[sidx] = (snp_cmd == 1) ? 1 : 0;
      if (snp_valid && snp_cmd >= 2 && m_pk == 2 && (int'(snp_addr) >> OFF_W) == m_pline)
        m_pk = 3;
      if (e_cmdv) begin
        m_st[pidx]  = (m_pk == 1) ? (bus_shared_in ? 1 : 2) : 3;
        m_tag[pidx] = ptag;
        m_pk = 0;
        nd = 1;
      end
      if (acc) begin
        cidx = (int'(cpu_addr) >> OFF_W) & (LINES - 1);
        ctag = int'(cpu_addr) >> (OFF_W + IDX_W);
        chit = m_st[cidx] != 0 && m_tag[cidx] == ctag;
        if (!cpu_write) begin
          if (chit) nd = 1; else m_pk = 1;
        end else if (chit && m_st[cidx] >= 2) begin
          m_st[cidx] = 3; nd = 1;
        end else if (chit) m_pk = 2;
        else m_pk = 3;
        if (m_pk != 0) m_pline = int'(cpu_addr) >> OFF_W;
      end
      m_done = nd;
      last_acc = acc;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr();
    cpu_valid = 0; cpu_write = 0; cpu_addr = '0;
    bus_gnt = 0; bus_shared_in = 0;
    snp_valid = 0; snp_cmd = 2'b00; snp_addr = '0;
  endtask

  task automatic settle();
    @(posedge clk); #1; clr();
  endtask

  task automatic cpu_go(input bit w, input int a);
    cpu_valid = 1; cpu_write = w; cpu_addr = ADDR_W'(a);
    @(negedge clk);
    check(cpu_ready === 1'b1, "R8", "ready for request", cpu_ready, 1);
    settle();
  endtask

  task automatic grant_go(input bit sh, input int exp_cmd, input string rq);
    bus_gnt = 1; bus_shared_in = sh;
    @(negedge clk);
    check(bus_cmd_valid === 1'b1 && int'(bus_cmd) == exp_cmd, rq, "granted command", bus_cmd, exp_cmd);
    settle();
  endtask

  task automatic snoop_go(input int cmd, input int a, input bit esh, input bit edt, input string rq);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = ADDR_W'(a);
    @(negedge clk);
    check(snp_shared === esh, rq, "snoop shared", snp_shared, esh);
    check(snp_dirty === edt, rq, "snoop dirty", snp_dirty, edt);
    check(cpu_ready === 1'b0, "R8", "ready during snoop", cpu_ready, 0);
    settle();
  endtask

  task automatic expect_done(input string rq);
    @(negedge clk);
    check(cpu_done === 1'b1, rq, "done pulse", cpu_done, 1);
    settle();
  endtask

  // ---------------- directed and random sequences ----------------
  initial begin
    int A, B, D, X;
    A = mk(1, 0); B = mk(1, 1); D = mk(1, 3); X = mk(2, 0);
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    @(negedge clk);
    check(cpu_ready === 1'b1 && bus_req === 1'b0, "R1", "idle after reset", {cpu_ready, bus_req}, 2'b10);
    settle();
    snoop_go(1, A, 0, 0, "R1");

    // read miss, filled E
    cpu_go(0, A);
    @(negedge clk);
    check(bus_req === 1'b1 && cpu_ready === 1'b0, "R2", "request waits", {bus_req, cpu_ready}, 2'b10);
    check(int'(bus_cmd_addr) == A, "R10", "waiting address", bus_cmd_addr, A);
    settle();
    grant_go(0, 1, "R2");
    expect_done("R2");

    // silent E->M, seen by the snoop copy
    cpu_go(1, A + 5);
    @(negedge clk);
    check(cpu_done === 1'b1 && bus_req === 1'b0, "R3", "silent write hit", {cpu_done, bus_req}, 2'b10);
    settle();
    snoop_go(1, A, 1, 1, "R13");
    snoop_go(1, A, 1, 0, "R6");

    // D into E, then upgrade A while snooping D
    cpu_go(0, D); settle(); grant_go(0, 1, "R2"); settle();
    cpu_go(1, A);
    @(negedge clk);
    check(bus_req === 1'b1, "R4", "upgrade waits for bus", bus_req, 1);
    settle();
    snoop_go(1, D, 1, 0, "R9");
    grant_go(0, 3, "R4");
    expect_done("R4");

    // B filled S, then invalidated by a snoop
    cpu_go(0, B); settle(); grant_go(1, 1, "R2"); settle();
    snoop_go(2, B, 1, 0, "R7");
    snoop_go(1, B, 0, 0, "R7");

    // conflict: waiting upgrade becomes read-exclusive
    cpu_go(0, B); settle(); grant_go(1, 1, "R2"); settle();
    cpu_go(1, B); settle();
    snoop_go(2, B, 1, 0, "R5");
    @(negedge clk);
    check(bus_req === 1'b1, "R5", "request survives conflict", bus_req, 1);
    settle();
    grant_go(0, 2, "R5");
    settle();
    snoop_go(1, B, 1, 1, "R5");

    // snoop-made S visible to processor: write now needs the bus
    cpu_go(1, B);
    @(negedge clk);
    check(bus_req === 1'b1, "R13", "write to snooped-S line", bus_req, 1);
    settle();
    grant_go(0, 3, "R4"); settle();

    // write miss evicting dirty A
    cpu_go(1, X); settle();
    bus_gnt = 1;
    @(negedge clk);
    check(int'(bus_cmd) == 2, "R10", "write-miss command", bus_cmd, 2);
    check(bus_wb_valid === 1'b1 && int'(bus_wb_addr) == A, "R11", "victim address", bus_wb_addr, A);
    settle();
    expect_done("R10");
    snoop_go(1, X, 1, 1, "R10");
    snoop_go(1, A, 0, 0, "R11");
    snoop_go(1, mk(3, 0) + 9, 0, 0, "R12");
    @(negedge clk);
    check(snp_shared === 1'b0 && snp_dirty === 1'b0, "R12", "no snoop no response",
          {snp_shared, snp_dirty}, 0);
    settle();

    // random phase, keeping the bus and handshake rules
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(posedge clk); #1;
      if (cpu_valid && last_acc) cpu_valid = 0;
      if (!cpu_valid && ($urandom % 3 == 0)) begin
        cpu_valid = 1;
        cpu_write = $urandom % 2;
        cpu_addr  = ADDR_W'(mk(1 + $urandom % 2, $urandom % LINES) + $urandom % 16);
      end
      bus_shared_in = $urandom % 2;
      if (m_pk != 0 && ($urandom % 4 == 0)) begin
        bus_gnt = 1; snp_valid = 0;
      end else begin
        bus_gnt = 0;
        snp_valid = ($urandom % 3 == 0);
        snp_cmd   = 2'(1 + $urandom % 3);
        snp_addr  = ADDR_W'(mk(1 + $urandom % 2, $urandom % LINES) + $urandom % 16);
      end
    end
    settle();
    repeat (2) @(posedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule